// File: doc/BRIEF.md
# Flash Erase Status Bit Generator

This block is the device-side source of the status byte that a NOR flash returns while a program or erase runs inside the part. A system polls the device with ordinary read cycles; depending on the current mode the block answers with array data or with a status byte made of a ready flag, a mode toggle bit, a timeout flag and a sector toggle bit. Reading two status bytes in a row shows whether work is still going on, whether an erase is running or suspended, which sectors are part of the erase, and whether the operation has failed.

A small command input stands in for the command decoder: a one-cycle write strobe with an operation code starts a program or an erase, suspends or resumes an erase, or clears a failure. Operation time is modelled by pulse counters that advance once per clock while the operation runs; a program that tries to turn a 0 cell back into a 1 stalls until the pulse limit runs out and the block latches a failure that only the reset command clears.

Top module: `flash_status_gen`

## Requirements
- R1: A read cycle starts on the clock where the AND of `oe_i` and `ce_i` first goes high, whichever of the two arrives last; `dq_o` changes only one clock after such a start and holds its value on every other clock. In read-array mode it shows the `array_i` value present at the start.
- R2: Command codes on `cmd_op_i`, taken when `cmd_we_i` is high: 1 program, 2 erase, 3 suspend, 4 resume, 5 reset, others no-op. A status byte has bit 7 ready, bit 6 mode toggle, bit 5 timeout, bit 2 sector toggle, all other bits 0.
- R3: The sector toggle bit inverts on every read start whose `rd_sec_i` is a sector latched from `erase_sel_i` by the erase command, both while erasing and while erase-suspended; reads to other sectors leave it unchanged.
- R4: The mode toggle bit inverts on every read start while a program or erase runs or after a failure, and holds while the erase is suspended.
- R5: While an erase is suspended, a read of an unselected sector returns array data and a read of a selected sector returns a status byte with bit 7 set.
- R6: A program ends PROG_CYCLES clocks after its command and an erase ERASE_CYCLES running clocks after its command (suspended clocks do not count); the mode returns to read-array, or to erase-suspended for a program issued in suspend, and the next read returns array data.
- R7: A program issued with `prog_conflict_i` high never completes; PULSE_LIMIT clocks after the command the block enters the failed mode and status reads show bit 5 set.
- R8: The failed mode holds until a reset command, which returns to erase-suspended if the failure came from a program issued during suspend and to read-array otherwise.
- R9: A command that does not fit the current mode has no effect (for example reset or program during an erase, resume in read-array).
- R10: After reset the mode is read-array, both toggle bits are 0 and `dq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oe_i | input | 1 | Output enable strobe, active high |
| ce_i | input | 1 | Chip enable strobe, active high |
| rd_sec_i | input | SEC_W | Sector index of the read address |
| array_i | input | 8 | Array contents at the read address |
| cmd_we_i | input | 1 | Command write strobe, one cycle per command |
| cmd_op_i | input | 3 | Command code |
| erase_sel_i | input | NUM_SEC | Sectors chosen by an erase command |
| prog_conflict_i | input | 1 | Program data would turn a 0 cell into a 1 |
| dq_o | output | 8 | Read data bus |

## Verification
Reads are driven with both strobes together and with the chip enable arriving after the output enable, so that the start-of-read rule is separated from a level-sensitive one. During an erase, reads alternate between selected and unselected sectors, which separates the sector toggle from the mode toggle; the same reads repeated under suspend show the mode toggle freezing while the sector toggle keeps moving and unselected sectors fall back to array data. A clean program, a conflicting program from read-array and a conflicting program inside a suspended erase tell apart the completion path, the timeout path and the two return targets of reset, while misplaced commands in each mode are checked for having no effect on later reads.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        M_READ   = 3'd0,
        M_PROG   = 3'd1,
        M_ERASE  = 3'd2,
        M_ESUSP  = 3'd3,
        M_ESPROG = 3'd4,
        M_FAIL   = 3'd5
    } fsg_mode_e;

    typedef enum logic [2:0] {
        C_NOP    = 3'd0,
        C_PROG   = 3'd1,
        C_ERASE  = 3'd2,
        C_SUSP   = 3'd3,
        C_RESUME = 3'd4,
        C_RESET  = 3'd5
    } fsg_cmd_e;

    typedef struct packed {
        fsg_mode_e  mode;
        logic       mode_tog;
        logic       sec_tog;
        logic       fail_ret;
        logic [7:0] dq;
    } fsg_state_t;

endpackage

// File: rtl/fsg_rd_edge.sv
module fsg_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_i,
    input  logic ce_i,
    output logic start_o
);
    logic act;
    logic act_d, act_q;

    always_comb begin
        act     = oe_i & ce_i;
        act_d   = act;
        start_o = act & ~act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end
endmodule

// File: rtl/fsg_pulse_ctr.sv
module fsg_pulse_ctr #(
    parameter int DUR   = 6,
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic halt_i,
    input  logic run_i,
    output logic done_o,
    output logic expire_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, cnt_inc;
    logic             halt_d, halt_q;

    always_comb begin
        cnt_inc  = cnt_q + CNT_W'(1);
        done_o   = run_i & ~halt_q & (cnt_inc == CNT_W'(DUR));
        expire_o = run_i & ~done_o & (cnt_inc == CNT_W'(LIMIT));
        cnt_d    = cnt_q;
        halt_d   = halt_q;
        if (clr_i) begin
            cnt_d  = '0;
            halt_d = halt_i;
        end else if (run_i && cnt_q != CNT_W'(LIMIT)) begin
            cnt_d = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            halt_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            halt_q <= halt_d;
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int NUM_SEC      = 8,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 20,
    parameter int PULSE_LIMIT  = 40,
    localparam int SEC_W       = $clog2(NUM_SEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               oe_i,
    input  logic               ce_i,
    input  logic [SEC_W-1:0]   rd_sec_i,
    input  logic [7:0]         array_i,
    input  logic               cmd_we_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [NUM_SEC-1:0] erase_sel_i,
    input  logic               prog_conflict_i,
    output logic [7:0]         dq_o
);
    fsg_state_t         st_d, st_q;
    logic [NUM_SEC-1:0] sel_d, sel_q;
    fsg_cmd_e           cmd;
    logic               rd_start;
    logic               p_clr, p_run, p_done, p_exp;
    logic               e_clr, e_run, e_done, e_exp;
    logic               sel_hit, mt_flip, st_flip, show_array;

    assign cmd = cmd_we_i ? fsg_cmd_e'(cmd_op_i) : C_NOP;

    fsg_rd_edge u_rd_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_i   (oe_i),
        .ce_i   (ce_i),
        .start_o(rd_start)
    );

    fsg_pulse_ctr #(.DUR(PROG_CYCLES), .LIMIT(PULSE_LIMIT)) u_prog_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (p_clr),
        .halt_i  (prog_conflict_i),
        .run_i   (p_run),
        .done_o  (p_done),
        .expire_o(p_exp)
    );

    fsg_pulse_ctr #(.DUR(ERASE_CYCLES), .LIMIT(PULSE_LIMIT)) u_erase_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (e_clr),
        .halt_i  (1'b0),
        .run_i   (e_run),
        .done_o  (e_done),
        .expire_o(e_exp)
    );

    always_comb begin
        st_d  = st_q;
        sel_d = sel_q;
        p_run = (st_q.mode == M_PROG) || (st_q.mode == M_ESPROG);
        e_run = (st_q.mode == M_ERASE);
        p_clr = 1'b0;
        e_clr = 1'b0;

        // read path: toggles and the byte driven onto the bus
        sel_hit    = sel_q[rd_sec_i];
        mt_flip    = p_run || e_run || (st_q.mode == M_FAIL);
        st_flip    = sel_hit && ((st_q.mode == M_ERASE) || (st_q.mode == M_ESUSP));
        show_array = (st_q.mode == M_READ) || ((st_q.mode == M_ESUSP) && !sel_hit);
        if (rd_start) begin
            st_d.mode_tog = st_q.mode_tog ^ mt_flip;
            st_d.sec_tog  = st_q.sec_tog ^ st_flip;
            if (show_array) st_d.dq = array_i;
            else st_d.dq = {st_q.mode == M_ESUSP, st_d.mode_tog, st_q.mode == M_FAIL,
                            2'b00, st_d.sec_tog, 2'b00};
        end

        // mode path: completion and timeout before commands
        case (st_q.mode)
            M_READ: begin
                if (cmd == C_PROG) begin
                    st_d.mode = M_PROG;
                    p_clr     = 1'b1;
                end else if (cmd == C_ERASE) begin
                    st_d.mode = M_ERASE;
                    sel_d     = erase_sel_i;
                    e_clr     = 1'b1;
                end
            end
            M_PROG: begin
                if (p_done) st_d.mode = M_READ;
                else if (p_exp) begin
                    st_d.mode     = M_FAIL;
                    st_d.fail_ret = 1'b0;
                end
            end
            M_ERASE: begin
                if (e_done) begin
                    st_d.mode = M_READ;
                    sel_d     = '0;
                end else if (e_exp) begin
                    st_d.mode     = M_FAIL;
                    st_d.fail_ret = 1'b0;
                end else if (cmd == C_SUSP) st_d.mode = M_ESUSP;
            end
            M_ESUSP: begin
                if (cmd == C_PROG) begin
                    st_d.mode = M_ESPROG;
                    p_clr     = 1'b1;
                end else if (cmd == C_RESUME) st_d.mode = M_ERASE;
            end
            M_ESPROG: begin
                if (p_done) st_d.mode = M_ESUSP;
                else if (p_exp) begin
                    st_d.mode     = M_FAIL;
                    st_d.fail_ret = 1'b1;
                end
            end
            M_FAIL: begin
                if (cmd == C_RESET) st_d.mode = st_q.fail_ret ? M_ESUSP : M_READ;
            end
            default: st_d.mode = M_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '{mode: M_READ, mode_tog: 1'b0, sec_tog: 1'b0,
                       fail_ret: 1'b0, dq: 8'h00};
            sel_q <= '0;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_d;
        end
    end

    assign dq_o = st_q.dq;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
    import fsg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_start,
    input logic       cmd_we,
    input logic [2:0] cmd_op,
    input logic [7:0] array_i,
    input logic [7:0] dq,
    input fsg_mode_e  mode,
    input logic       mode_tog,
    input logic       fail_ret
);
    logic reset_cmd;
    assign reset_cmd = cmd_we && (cmd_op == 3'd5);

    AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> $stable(dq)); // R1

    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && mode == M_READ) |=> (dq == $past(array_i))); // R1

    AST_MODE_TOG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && mode == M_ERASE) |=> (mode_tog != $past(mode_tog))); // R4

    AST_MODE_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && mode == M_ESUSP) |=> $stable(mode_tog)); // R4

    AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && mode == M_FAIL) |=> dq[5]); // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_FAIL && !reset_cmd) |=> (mode == M_FAIL)); // R8

    AST_RESET_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_FAIL && reset_cmd) |=>
        (mode == ($past(fail_ret) ? M_ESUSP : M_READ))); // R8
endmodule

bind flash_status_gen fsg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_start(rd_start),
    .cmd_we  (cmd_we_i),
    .cmd_op  (cmd_op_i),
    .array_i (array_i),
    .dq      (dq_o),
    .mode    (st_q.mode),
    .mode_tog(st_q.mode_tog),
    .fail_ret(st_q.fail_ret)
);

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;
    localparam int NS  = 8;
    localparam int PC  = 6;
    localparam int EC  = 20;
    localparam int LIM = 40;
    // model mode codes
    localparam int RD = 0, PG = 1, ER = 2, SU = 3, SP = 4, FL = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oe = 1'b0, ce = 1'b0;
    logic [2:0]    rd_sec = '0;
    logic [7:0]    arr = '0;
    logic          cmd_we = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [NS-1:0] esel = '0;
    logic          conf = 1'b0;
    logic [7:0]    dq;

    always #2 clk = ~clk;

    flash_status_gen #(.NUM_SEC(NS), .PROG_CYCLES(PC), .ERASE_CYCLES(EC),
                       .PULSE_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .oe_i(oe), .ce_i(ce), .rd_sec_i(rd_sec),
        .array_i(arr), .cmd_we_i(cmd_we), .cmd_op_i(cmd_op),
        .erase_sel_i(esel), .prog_conflict_i(conf), .dq_o(dq));

    int    n_vec = 0, n_bad = 0, cycles = 0;
    string phase = "R10";

    // behavioural reference model
    int         m_mode, m_ret, m_pc, m_ec;
    bit         m_halt, m_mt, m_st, m_prev;
    bit [NS-1:0] m_sel;
    logic [7:0] m_dq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = RD; m_ret = 0; m_pc = 0; m_ec = 0; m_halt = 0;
            m_mt = 0; m_st = 0; m_prev = 0; m_sel = '0; m_dq = 8'h00;
        end else begin
            int  om;
            bit  act, start, prun, erun, pdone, pexp, edone, eexp, hit;
            int  c;
            om    = m_mode;
            act   = oe && ce;
            start = act && !m_prev;
            m_prev = act;
            c     = cmd_we ? int'(cmd_op) : 0;
            hit   = m_sel[rd_sec];
            if (start) begin
                if (om == PG || om == ER || om == SP || om == FL) m_mt = !m_mt;
                if ((om == ER || om == SU) && hit) m_st = !m_st;
                if (om == RD || (om == SU && !hit)) m_dq = arr;
                else begin
                    m_dq = 8'h00;
                    m_dq[7] = (om == SU);
                    m_dq[6] = m_mt;
                    m_dq[5] = (om == FL);
                    m_dq[2] = m_st;
                end
            end
            prun  = (om == PG || om == SP);
            erun  = (om == ER);
            pdone = prun && !m_halt && (m_pc + 1 == PC);
            pexp  = prun && !pdone && (m_pc + 1 == LIM);
            edone = erun && (m_ec + 1 == EC);
            eexp  = erun && !edone && (m_ec + 1 == LIM);
            if (prun && m_pc < LIM) m_pc++;
            if (erun && m_ec < LIM) m_ec++;
            case (om)
                RD: if (c == 1) begin m_mode = PG; m_pc = 0; m_halt = conf; end
                    else if (c == 2) begin m_mode = ER; m_ec = 0; m_sel = esel; end
                PG: if (pdone) m_mode = RD; else if (pexp) begin m_mode = FL; m_ret = 0; end
                ER: if (edone) begin m_mode = RD; m_sel = '0; end
                    else if (eexp) begin m_mode = FL; m_ret = 0; end
                    else if (c == 3) m_mode = SU;
                SU: if (c == 1) begin m_mode = SP; m_pc = 0; m_halt = conf; end
                    else if (c == 4) m_mode = ER;
                SP: if (pdone) m_mode = SU; else if (pexp) begin m_mode = FL; m_ret = 1; end
                FL: if (c == 5) m_mode = m_ret ? SU : RD;
                default: m_mode = RD;
            endcase
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (dq !== m_dq) begin
                n_bad++;
                $display("FAIL %s: dq actual %h expected %h at cycle %0d",
                         phase, dq, m_dq, cycles);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input int sec, input logic [7:0] d);
        rd_sec = sec[2:0]; arr = d; oe = 1'b1; ce = 1'b1;
        @(negedge clk);
        oe = 1'b0; ce = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_ce_last(input int sec, input logic [7:0] d);
        rd_sec = sec[2:0]; arr = d; oe = 1'b1;
        @(negedge clk);
        arr = 8'hFF;          // not captured: read not yet started
        @(negedge clk);
        arr = d; ce = 1'b1;
        @(negedge clk);
        arr = 8'h00;          // held value must not follow
        @(negedge clk);
        oe = 1'b0; ce = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd(input int op, input logic [NS-1:0] s, input bit cf);
        cmd_we = 1'b1; cmd_op = op[2:0]; esel = s; conf = cf;
        @(negedge clk);
        cmd_we = 1'b0; cmd_op = 3'd0; conf = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    logic [7:0] s1, s2;

    initial begin
        idle(3);
        chk(dq === 8'h00, "R10", dq, 8'h00);
        rst_n = 1'b1;
        idle(2);
        chk(dq === 8'h00, "R10", dq, 8'h00);

        phase = "R1";
        rd(0, 8'hA5);
        chk(dq === 8'hA5, "R1", dq, 8'hA5);
        rd_ce_last(3, 8'h3C);
        chk(dq === 8'h3C, "R1", dq, 8'h3C);

        phase = "R9";
        cmd(4, '0, 0); cmd(5, '0, 0); cmd(3, '0, 0);
        rd(1, 8'h5A);
        chk(dq === 8'h5A, "R9", dq, 8'h5A);

        phase = "R6";
        cmd(1, '0, 0);
        rd(0, 8'h11); s1 = dq;
        rd(0, 8'h11); s2 = dq;
        chk(s1[6] != s2[6], "R4", s2, s1 ^ 8'h40);
        chk(s1[7] == 1'b0 && s1[5] == 1'b0, "R2", s1, s1 & 8'h5F);
        idle(4);
        rd(0, 8'h77);
        chk(dq === 8'h77, "R6", dq, 8'h77);

        phase = "R3";
        cmd(2, 8'b0000_0110, 0);
        rd(1, 8'h00); s1 = dq;
        rd(5, 8'h00); s2 = dq;
        chk(s1[2] == s2[2], "R3", s2, s1);
        chk(s1[6] != s2[6], "R4", s2, s1 ^ 8'h40);
        rd(2, 8'h00);
        chk(dq[2] != s2[2], "R3", dq, s2 ^ 8'h04);
        phase = "R9";
        cmd(5, '0, 0); cmd(1, '0, 0);

        phase = "R5";
        cmd(3, '0, 0);
        rd(1, 8'h00); s1 = dq;
        chk(s1[7] == 1'b1, "R5", s1, s1 | 8'h80);
        rd(2, 8'h00); s2 = dq;
        chk(s1[6] == s2[6], "R4", s2, s1);
        chk(s1[2] != s2[2], "R3", s2, s1 ^ 8'h04);
        rd(0, 8'hC3);
        chk(dq === 8'hC3, "R5", dq, 8'hC3);
        idle(30);
        cmd(1, '0, 0);
        rd(6, 8'h00);
        chk(dq[7] == 1'b0, "R6", dq, dq & 8'h7F);
        idle(6);
        rd(0, 8'h99);
        chk(dq === 8'h99, "R6", dq, 8'h99);
        phase = "R6";
        cmd(4, '0, 0);
        idle(20);
        rd(1, 8'h42);
        chk(dq === 8'h42, "R6", dq, 8'h42);

        phase = "R7";
        cmd(1, '0, 1);
        idle(LIM + 2);
        rd(0, 8'h00);
        chk(dq[5] == 1'b1, "R7", dq, dq | 8'h20);
        phase = "R8";
        cmd(4, '0, 0);
        idle(10);
        rd(0, 8'h00);
        chk(dq[5] == 1'b1, "R8", dq, dq | 8'h20);
        cmd(5, '0, 0);
        rd(0, 8'h24);
        chk(dq === 8'h24, "R8", dq, 8'h24);

        phase = "R8";
        cmd(2, 8'b1000_0001, 0);
        idle(2);
        cmd(3, '0, 0);
        cmd(1, '0, 1);
        idle(LIM + 2);
        rd(7, 8'h00);
        chk(dq[5] == 1'b1, "R7", dq, dq | 8'h20);
        cmd(5, '0, 0);
        rd(7, 8'h00);
        chk(dq[7] == 1'b1 && dq[5] == 1'b0, "R8", dq, 8'h80 | (dq & 8'h44));
        rd(4, 8'h6E);
        chk(dq === 8'h6E, "R5", dq, 8'h6E);
        phase = "R6";
        cmd(4, '0, 0);
        idle(EC + 2);
        rd(0, 8'hE1);
        chk(dq === 8'hE1, "R6", dq, 8'hE1);

        idle(2);
        finish_up();
    end
endmodule